// File: doc/BRIEF.md
# Memory Address-Range Protection Checker

This block sits in front of a memory controller and gives a verdict on every memory transaction: accept or reject. Each transaction brings a byte address, a 12-bit master ID, a source port number and a secure/non-secure attribute. The block compares it against a table of protection rules in parallel. Each rule covers a megabyte-granular address window with an inclusive upper bound, an inclusive master-ID window, a set of permitted ports and a security mode. When no valid rule matches, a per-port default bit gives the verdict.

Software never touches the rule table directly. It fills three staging words (address window, ID window, rule attributes) and then writes a command word. The command word holds a rule index plus a commit bit or a fetch bit. A commit copies the staging words into the indexed rule. A fetch copies the indexed rule back into the staging words, where software can read it. The verdict is registered and arrives one clock after the transaction.

Top module: `mrg_top`

## Requirements
- R1: After reset every rule is invalid and the default word is 0. All transactions are accepted, and every configuration word reads back as 0.
- R2: A write to the command word (offset 3) with bit 5 set copies the address, ID and attribute staging words into the rule whose index is in bits 4:0.
- R3: A write to the command word with bit 6 set and bit 5 clear copies the indexed rule into the staging words (offsets 0, 1, 2), where software can read it back.
- R4: A commit or fetch with an index of 20 or above changes neither the rule table nor the staging words.
- R5: The address staging word (offset 0) holds the first megabyte in bits 11:0 and the last included megabyte in bits 23:12. A rule covers the address when address bits 31:20 lie within that range, both ends included.
- R6: The ID staging word (offset 1) holds the lowest ID in bits 11:0 and the highest ID in bits 23:12. A rule covers the ID when it lies within that range, both ends included.
- R7: In the attribute word (offset 2), bits 12:3 are a port mask with one bit per port. A rule covers a port only when that port's bit is set. A transaction whose port number is 10 or above matches no rule and is always rejected.
- R8: Attribute bits 1:0 give the security mode. Bit 0 lets secure transactions match and bit 1 lets non-secure transactions match.
- R9: A rule whose valid flag (attribute bit 2) is clear never matches.
- R10: When several rules match, the lowest-numbered one decides. Its result bit (attribute bit 13) gives the verdict: 1 rejects and 0 accepts.
- R11: When no valid rule matches, bit p of the default word (offset 4) gives the verdict for port p: 1 rejects and 0 accepts.
- R12: The verdict appears exactly one clock after a transaction is presented. It is flagged valid only in that cycle, and the reject output is low whenever the verdict is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for the word at cfg_addr |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | 32 | Transaction byte address |
| txn_id | input | 12 | Master ID |
| txn_port | input | 4 | Source port number |
| txn_secure | input | 1 | 1 for a secure transaction |
| verdict_valid | output | 1 | Verdict is present this cycle |
| verdict_reject | output | 1 | 1 rejects the transaction, 0 accepts it |

## Verification
The bench checks addresses on the last megabyte of a window. A design that treated the upper bound as exclusive would send those addresses to the default and reject them. The bench also checks IDs and ports one step outside a rule. A mask or range test that was off by one would let those transactions reach a reject rule. Overlapping rules with opposite results check that the lowest index wins; a highest-index or OR-combined selection would flip those verdicts. Further checks cover an invalid rule sitting on an address that otherwise goes to the default, a fetch and a commit aimed at index 20 (which must alter nothing), and a partial default word that must reject on one port and accept on another.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int unsigned MB_W   = 12;
  localparam int unsigned ID_W   = 12;
  localparam int unsigned PORT_W = 4;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;

  // configuration word offsets
  localparam logic [2:0] OFS_WIN  = 3'd0;
  localparam logic [2:0] OFS_IDS  = 3'd1;
  localparam logic [2:0] OFS_ATTR = 3'd2;
  localparam logic [2:0] OFS_CMD  = 3'd3;
  localparam logic [2:0] OFS_DFLT = 3'd4;

  // command word layout
  localparam int unsigned CMD_IDX_W  = 5;
  localparam int unsigned CMD_COMMIT = 5;
  localparam int unsigned CMD_FETCH  = 6;

  // attribute word layout
  localparam int unsigned ATTR_VALID = 2;
  localparam int unsigned ATTR_MASK  = 3;

  typedef struct packed {
    logic              valid;
    logic [1:0]        sec;
    logic              result;
    logic [MB_W-1:0]   mb_lo;
    logic [MB_W-1:0]   mb_hi;
    logic [ID_W-1:0]   id_lo;
    logic [ID_W-1:0]   id_hi;
  } rule_core_t;
endpackage

// File: rtl/mrg_regfile.sv
module mrg_regfile
  import mrg_pkg::*;
#(
  parameter int unsigned NRULES = 20,
  parameter int unsigned NPORTS = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [2:0]                    cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-1:0]             cfg_rdata,
  output rule_core_t                    rule_core [NRULES],
  output logic [NPORTS-1:0]             rule_mask [NRULES],
  output logic [NPORTS-1:0]             dflt_q
);
  localparam int unsigned ATTR_RES = ATTR_MASK + NPORTS;
  localparam int unsigned ATTR_W   = ATTR_RES + 1;

  logic [2*MB_W-1:0]    win_q, win_d;
  logic [2*ID_W-1:0]    ids_q, ids_d;
  logic [ATTR_W-1:0]    attr_q, attr_d;
  logic [CMD_IDX_W-1:0] idx_q, idx_d;
  logic [NPORTS-1:0]    dflt_d;
  rule_core_t           core_q [NRULES];
  rule_core_t           core_d [NRULES];
  logic [NPORTS-1:0]    mask_q [NRULES];
  logic [NPORTS-1:0]    mask_d [NRULES];

  logic                 cmd_wr, idx_ok, do_commit, do_fetch;
  logic [CMD_IDX_W-1:0] wr_idx;
  rule_core_t           staged;
  rule_core_t           fetched;
  logic [NPORTS-1:0]    fetched_mask;

  assign cmd_wr    = cfg_we && (cfg_addr == OFS_CMD);
  assign wr_idx    = cfg_wdata[CMD_IDX_W-1:0];
  assign idx_ok    = (32'(wr_idx) < NRULES);
  assign do_commit = cmd_wr && idx_ok && cfg_wdata[CMD_COMMIT];
  assign do_fetch  = cmd_wr && idx_ok && cfg_wdata[CMD_FETCH] && !cfg_wdata[CMD_COMMIT];

  always_comb begin
    staged.valid  = attr_q[ATTR_VALID];
    staged.sec    = attr_q[1:0];
    staged.result = attr_q[ATTR_RES];
    staged.mb_lo  = win_q[MB_W-1:0];
    staged.mb_hi  = win_q[2*MB_W-1:MB_W];
    staged.id_lo  = ids_q[ID_W-1:0];
    staged.id_hi  = ids_q[2*ID_W-1:ID_W];
    fetched       = '0;
    fetched_mask  = '0;
    for (int i = 0; i < NRULES; i++) begin
      if (32'(wr_idx) == i) begin
        fetched      = core_q[i];
        fetched_mask = mask_q[i];
      end
    end
  end

  always_comb begin
    win_d  = win_q;
    ids_d  = ids_q;
    attr_d = attr_q;
    idx_d  = idx_q;
    dflt_d = dflt_q;
    if (cfg_we) begin
      unique case (cfg_addr)
        OFS_WIN:  win_d  = cfg_wdata[2*MB_W-1:0];
        OFS_IDS:  ids_d  = cfg_wdata[2*ID_W-1:0];
        OFS_ATTR: attr_d = cfg_wdata[ATTR_W-1:0];
        OFS_CMD:  idx_d  = wr_idx;
        OFS_DFLT: dflt_d = cfg_wdata[NPORTS-1:0];
        default: ;
      endcase
    end
    if (do_fetch) begin
      win_d  = {fetched.mb_hi, fetched.mb_lo};
      ids_d  = {fetched.id_hi, fetched.id_lo};
      attr_d = {fetched.result, fetched_mask, fetched.valid, fetched.sec};
    end
  end

  generate
    for (genvar g = 0; g < NRULES; g++) begin : g_rule
      logic hit_sel;
      assign hit_sel = do_commit && (32'(wr_idx) == g);
      always_comb begin
        core_d[g] = hit_sel ? staged : core_q[g];
        mask_d[g] = hit_sel ? attr_q[ATTR_RES-1:ATTR_MASK] : mask_q[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          core_q[g] <= '0;
          mask_q[g] <= '0;
        end else if (hit_sel) begin
          core_q[g] <= core_d[g];
          mask_q[g] <= mask_d[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      ids_q  <= '0;
      attr_q <= '0;
      idx_q  <= '0;
      dflt_q <= '0;
    end else if (cfg_we) begin
      win_q  <= win_d;
      ids_q  <= ids_d;
      attr_q <= attr_d;
      idx_q  <= idx_d;
      dflt_q <= dflt_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      OFS_WIN:  cfg_rdata[2*MB_W-1:0]    = win_q;
      OFS_IDS:  cfg_rdata[2*ID_W-1:0]    = ids_q;
      OFS_ATTR: cfg_rdata[ATTR_W-1:0]    = attr_q;
      OFS_CMD:  cfg_rdata[CMD_IDX_W-1:0] = idx_q;
      OFS_DFLT: cfg_rdata[NPORTS-1:0]    = dflt_q;
      default: ;
    endcase
  end

  assign rule_core = core_q;
  assign rule_mask = mask_q;
endmodule

// File: rtl/mrg_rule_cmp.sv
module mrg_rule_cmp
  import mrg_pkg::*;
#(
  parameter int unsigned NPORTS = 10
) (
  input  rule_core_t         rule,
  input  logic [NPORTS-1:0]  mask,
  input  logic [MB_W-1:0]    mb,
  input  logic [ID_W-1:0]    id,
  input  logic [PORT_W-1:0]  port,
  input  logic               port_ok,
  input  logic               secure,
  output logic               hit
);
  logic in_win, in_ids, port_on, sec_on;
  always_comb begin
    in_win  = (mb >= rule.mb_lo) && (mb <= rule.mb_hi);
    in_ids  = (id >= rule.id_lo) && (id <= rule.id_hi);
    port_on = 1'b0;
    for (int p = 0; p < NPORTS; p++)
      if (32'(port) == p) port_on = mask[p];
    sec_on  = secure ? rule.sec[0] : rule.sec[1];
    hit     = rule.valid && in_win && in_ids && port_ok && port_on && sec_on;
  end
endmodule

// File: rtl/mrg_pick.sv
module mrg_pick #(
  parameter int unsigned NRULES = 20
) (
  input  logic [NRULES-1:0] hit_vec,
  output logic [NRULES-1:0] pick_vec,
  output logic              any_hit
);
  assign pick_vec = hit_vec & (~hit_vec + NRULES'(1));
  assign any_hit  = |hit_vec;
endmodule

// File: rtl/mrg_top.sv
module mrg_top
  import mrg_pkg::*;
#(
  parameter int unsigned NRULES = 20,
  parameter int unsigned NPORTS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        txn_valid,
  input  logic [31:0] txn_addr,
  input  logic [11:0] txn_id,
  input  logic [3:0]  txn_port,
  input  logic        txn_secure,
  output logic        verdict_valid,
  output logic        verdict_reject
);
  rule_core_t        rule_core [NRULES];
  logic [NPORTS-1:0] rule_mask [NRULES];
  logic [NPORTS-1:0] dflt_q;
  logic [NRULES-1:0] hit_vec, pick_vec, res_vec;
  logic              any_hit, port_ok, dflt_bit, reject_d;
  logic              vv_q, rej_q, rej_next;

  mrg_regfile #(.NRULES(NRULES), .NPORTS(NPORTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rule_core(rule_core), .rule_mask(rule_mask), .dflt_q(dflt_q)
  );

  assign port_ok = (32'(txn_port) < NPORTS);

  generate
    for (genvar g = 0; g < NRULES; g++) begin : g_cmp
      mrg_rule_cmp #(.NPORTS(NPORTS)) u_cmp (
        .rule(rule_core[g]), .mask(rule_mask[g]),
        .mb(txn_addr[ADDR_W-1:ADDR_W-MB_W]), .id(txn_id),
        .port(txn_port), .port_ok(port_ok), .secure(txn_secure),
        .hit(hit_vec[g])
      );
      assign res_vec[g] = rule_core[g].result;
    end
  endgenerate

  mrg_pick #(.NRULES(NRULES)) u_pick (
    .hit_vec(hit_vec), .pick_vec(pick_vec), .any_hit(any_hit)
  );

  always_comb begin
    dflt_bit = 1'b1;
    for (int p = 0; p < NPORTS; p++)
      if (32'(txn_port) == p) dflt_bit = dflt_q[p];
    reject_d = any_hit ? |(pick_vec & res_vec) : dflt_bit;
    rej_next = txn_valid && reject_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q  <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      vv_q  <= txn_valid;
      rej_q <= rej_next;
    end
  end

  assign verdict_valid  = vv_q;
  assign verdict_reject = rej_q;
endmodule

// File: rtl/mrg_chk.sv
module mrg_chk #(
  parameter int unsigned NRULES = 20,
  parameter int unsigned NPORTS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_valid,
  input logic [3:0]        txn_port,
  input logic              cfg_we,
  input logic [2:0]        cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              verdict_valid,
  input logic              verdict_reject,
  input logic [NRULES-1:0] hit_vec,
  input logic [NRULES-1:0] pick_vec,
  input logic [NRULES-1:0] res_vec
);
  // R12
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> verdict_valid);
  // R12
  verdict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !verdict_valid);
  // R12
  reject_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> !verdict_reject);
  // R10
  single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_vec) && ((pick_vec & ~hit_vec) == '0));
  // R10
  pick_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> (pick_vec != '0));
  // R7
  bad_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && (32'(txn_port) >= NPORTS)) |=> verdict_reject);
  // R4
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd3 && (32'(cfg_wdata[4:0]) >= NRULES)) |=> $stable(res_vec));
endmodule

bind mrg_top mrg_chk #(.NRULES(NRULES), .NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_port(txn_port),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .verdict_valid(verdict_valid), .verdict_reject(verdict_reject),
  .hit_vec(hit_vec), .pick_vec(pick_vec), .res_vec(res_vec)
);

// File: tb/mrg_top_tb.sv
module mrg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        txn_valid = 1'b0;
  logic [31:0] txn_addr = '0;
  logic [11:0] txn_id = '0;
  logic [3:0]  txn_port = '0;
  logic        txn_secure = 1'b0;
  logic        verdict_valid, verdict_reject;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mrg_top u_dut (.*);

  // {addr, id, port, secure, expected reject}
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {32'h0000_0000, 12'h005, 4'd0, 1'b0, 1'b0},
    {32'h0FFF_FFFF, 12'h000, 4'd9, 1'b1, 1'b0},
    {32'h1000_0000, 12'h010, 4'd1, 1'b1, 1'b1},
    {32'h1000_0000, 12'h010, 4'd1, 1'b0, 1'b0},
    {32'h1000_0000, 12'h020, 4'd1, 1'b1, 1'b0},
    {32'h1000_0000, 12'h01F, 4'd2, 1'b1, 1'b0},
    {32'h3000_0000, 12'h000, 4'd0, 1'b0, 1'b1},
    {32'h2FFF_FFFF, 12'h000, 4'd3, 1'b0, 1'b0},
    {32'h1FF0_0000, 12'h01F, 4'd0, 1'b1, 1'b1},
    {32'h0000_0000, 12'h000, 4'd10, 1'b0, 1'b1}
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic prog(input int idx, input logic [11:0] mlo, mhi, ilo, ihi,
                      input logic [1:0] sec, input logic vld,
                      input logic [9:0] mask, input logic res);
    wr(3'd0, {8'h0, mhi, mlo});
    wr(3'd1, {8'h0, ihi, ilo});
    wr(3'd2, {18'h0, res, mask, vld, sec});
    wr(3'd3, 32'(idx) | 32'h20);
  endtask

  task automatic send(input logic [31:0] a, input logic [11:0] id, input logic [3:0] p,
                      input logic s, output logic vv, output logic rj);
    @(negedge clk);
    txn_valid = 1'b1; txn_addr = a; txn_id = id; txn_port = p; txn_secure = s;
    @(negedge clk);
    txn_valid = 1'b0;
    vv = verdict_valid; rj = verdict_reject;
  endtask

  initial begin
    logic [31:0] r;
    logic vv, rj;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 verdict_valid", 32'(verdict_valid), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      check("R1 cfg word", r, 0);
    end
    send(32'h3000_0000, 12'h0, 4'd0, 1'b0, vv, rj);
    check("R12 verdict valid", 32'(vv), 1);
    check("R1 accept all", 32'(rj), 0);
    @(negedge clk);
    check("R12 valid drops", 32'(verdict_valid), 0);

    // R2 program table
    prog(0, 12'h000, 12'h0FF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
    prog(1, 12'h100, 12'h1FF, 12'h010, 12'h01F, 2'b01, 1'b1, 10'h003, 1'b1);
    prog(2, 12'h100, 12'h2FF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
    prog(5, 12'h300, 12'h300, 12'h000, 12'hFFF, 2'b10, 1'b0, 10'h3FF, 1'b0);
    wr(3'd4, 32'h3FF);

    // R5 R6 R7 R8 R9 R10 R11 vector walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][49:18], VEC[i][17:6], VEC[i][5:2], VEC[i][1], vv, rj);
      check("R5/R6/R7/R8/R9/R10/R11 vector", 32'(rj), 32'(VEC[i][0]));
    end

    // R3 fetch rule 1 into staging
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h41);
    rd(3'd0, r); check("R3 window readback", r, 32'h1FF100);
    rd(3'd1, r); check("R3 id readback", r, 32'h01F010);
    rd(3'd2, r); check("R3 attr readback", r, 32'h201D);
    rd(3'd3, r); check("R3 cmd index", r, 32'h1);

    // R4 fetch at index 20 leaves staging alone
    wr(3'd3, 32'h40 | 32'd20);
    rd(3'd0, r); check("R4 fetch ignored", r, 32'h1FF100);

    // R11 partial default: port 0 rejects, port 1 accepts
    wr(3'd4, 32'h001);
    send(32'h3000_0000, 12'h0, 4'd0, 1'b0, vv, rj);
    check("R11 port0 default", 32'(rj), 1);
    send(32'h3000_0000, 12'h0, 4'd1, 1'b0, vv, rj);
    check("R11 port1 default", 32'(rj), 0);

    // R4 commit at index 20 does nothing
    prog(20, 12'h300, 12'h300, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b1);
    send(32'h3000_0000, 12'h0, 4'd1, 1'b0, vv, rj);
    check("R4 commit ignored", 32'(rj), 0);

    // R9 validate rule 5 via commit: now matches non-secure accept
    prog(5, 12'h300, 12'h300, 12'h000, 12'hFFF, 2'b10, 1'b1, 10'h3FF, 1'b0);
    send(32'h3000_0000, 12'h0, 4'd0, 1'b0, vv, rj);
    check("R9 valid rule accepts", 32'(rj), 0);
    send(32'h3000_0000, 12'h0, 4'd0, 1'b1, vv, rj);
    check("R8 secure blocked by mode", 32'(rj), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule